// File: doc/BRIEF.md
# Histogram Burst Share Detector

This block inspects a 128-bin event-density histogram held in an external memory. It decides whether the histogram carries a second, high-density population of observation windows, which is the signature of deliberate contention on a shared resource. After a start pulse it reads every bin once, in ascending order, through a sequential read port with one cycle of latency. While reading, it looks for a valley bin to act as a threshold. It also accumulates the population of the non-zero bins.

When the scan ends, the block reports four results: the threshold index, the population from that threshold up to the top bin, and the population of bins 1 to 127. It also raises a flag when the burst population is more than half of that total. Bin 0 counts windows that had no contention events. It takes part in the valley test as the left neighbour of bin 1, but it never enters either sum. The results stay on the outputs until the next scan completes. A start pulse that arrives while a scan is running is dropped.

Top module: `burst_share_detector`

## Requirements
- R1: After reset, done, thrValid and burstFlag are low, and thrIdx, burstSum and totalSum are zero.
- R2: A start pulse seen while idle makes the block assert rdEn for 128 consecutive cycles. rdAddr steps through 0, 1, ..., 127 in that order. The memory returns rdData for an address in the cycle after rdEn presents it.
- R3: The threshold is the lowest index i in the range 1 to 126 for which h[i] < h[i-1] and h[i] <= h[i+1]. When such a bin exists, thrValid is high and thrIdx equals i. Bin 127 is never a candidate.
- R4: When no bin meets the R3 test, thrValid is low, thrIdx is zero, burstSum is zero and burstFlag is low.
- R5: totalSum equals the sum of bins 1 to 127. The contents of bin 0 never change it.
- R6: When a threshold exists, burstSum equals the sum of bins thrIdx to 127, with the threshold bin included.
- R7: burstFlag is high exactly when a threshold exists and 2*burstSum > totalSum. When the burst share is exactly one half, the flag stays low.
- R8: done is high for exactly one cycle. It rises on the 130th rising clock edge after the edge that samples start.
- R9: A start pulse during a running scan is ignored. The read sequence, the done timing and the results are the same as if that pulse had never arrived.
- R10: thrValid, thrIdx, burstSum, totalSum and burstFlag change only on the edge that raises done, and hold their values between scans.
- R11: The sums are 23 bits wide. A histogram with every bin at 0xFFFF yields totalSum = 127*65535 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to scan the histogram |
| rdEn | output | 1 | Read request to histogram memory |
| rdAddr | output | 7 | Bin index being read |
| rdData | input | 16 | Bin count, valid the cycle after the request |
| done | output | 1 | One-cycle pulse when results are updated |
| thrValid | output | 1 | A valley threshold was found |
| thrIdx | output | 7 | Threshold bin index (zero when none) |
| burstSum | output | 23 | Population of bins thrIdx..127 (zero when none) |
| totalSum | output | 23 | Population of bins 1..127 |
| burstFlag | output | 1 | Burst share exceeds one half |

## Verification
The hardest situations to reach are the edges of the valley search. These are a valley at bin 1, where only the excluded bin 0 makes bin 1 smaller than its neighbour, and a drop that occurs only at bin 127, where no right neighbour exists. Reaching a share that sits exactly at one half also needs a carefully tuned histogram. The bench writes histograms built for each of these cases: plateaus and ascending ramps that must yield no threshold, a late valley at bin 126, and two patterns whose burst share is exactly half and just above half. A second start is injected halfway through one scan, and the bench checks that the address sequence and done timing are undisturbed.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef struct packed {
    logic clear;        // new scan begins: reset accumulators
    logic dataValid;    // rdData holds a bin this cycle
    logic countBin;     // bin index is non-zero: add to total
    logic checkValley;  // bin index >= 2: previous bin may be tested
    logic finish;       // last bin absorbed: publish results
  } ctlStrobes_t;
endpackage

// File: rtl/bsd_control.sv
module bsd_control
  import bsd_pkg::*;
#(
  parameter int NUM_BINS = 128,
  parameter int IDX_W    = $clog2(NUM_BINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rdEn,
  output logic [IDX_W-1:0]  rdAddr,
  output logic [IDX_W-1:0]  dataIdx,
  output ctlStrobes_t       strobes
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BINS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_DRAIN} scanState_t;

  scanState_t       state;
  logic [IDX_W-1:0] addrQ;
  logic             validQ;
  logic [IDX_W-1:0] idxQ;
  logic             finishQ;

  assign rdEn   = (state == ST_READ);
  assign rdAddr = addrQ;
  assign dataIdx = idxQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      addrQ <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_READ;
          addrQ <= '0;
        end
        ST_READ: begin
          if (addrQ == LAST_IDX) state <= ST_DRAIN;
          else addrQ <= addrQ + IDX_W'(1);
        end
        ST_DRAIN: if (finishQ) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ  <= 1'b0;
      idxQ    <= '0;
      finishQ <= 1'b0;
    end else begin
      validQ  <= rdEn;
      idxQ    <= addrQ;
      finishQ <= validQ && (idxQ == LAST_IDX);
    end
  end

  always_comb begin
    strobes.clear       = (state == ST_IDLE) && start;
    strobes.dataValid   = validQ;
    strobes.countBin    = validQ && (idxQ != '0);
    strobes.checkValley = validQ && (idxQ > IDX_W'(1));
    strobes.finish      = finishQ;
  end

  // R2: reads advance one bin per cycle while the scan is active
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn && $past(rdEn) |-> rdAddr == $past(rdAddr) + IDX_W'(1));

  // R2: read requests are not interrupted before the last bin
  p_read_burst_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn && (rdAddr != LAST_IDX) |=> rdEn);

  // R9: a start pulse in mid-scan does not restart the address sequence
  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdEn && start && (rdAddr != LAST_IDX) |=> rdAddr != '0);
endmodule

// File: rtl/bsd_datapath.sv
module bsd_datapath
  import bsd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 7,
  parameter int SUM_W = CNT_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       strobes,
  input  logic [IDX_W-1:0]  dataIdx,
  input  logic [CNT_W-1:0]  rdData,
  output logic              done,
  output logic              thrValid,
  output logic [IDX_W-1:0]  thrIdx,
  output logic [SUM_W-1:0]  burstSum,
  output logic [SUM_W-1:0]  totalSum,
  output logic              burstFlag
);
  logic [CNT_W-1:0] prevBin;
  logic [CNT_W-1:0] curBin;
  logic [SUM_W-1:0] totalAcc;
  logic [SUM_W-1:0] belowAcc;   // population of bins 1..thr-1
  logic             foundQ;
  logic [IDX_W-1:0] thrQ;
  logic             isValley;
  logic [SUM_W-1:0] burstNext;
  logic             flagNext;

  assign isValley = strobes.checkValley && !foundQ &&
                    (curBin < prevBin) && (curBin <= rdData);

  always_comb begin
    burstNext = foundQ ? (totalAcc - belowAcc) : '0;
    flagNext  = foundQ && ({burstNext, 1'b0} > {1'b0, totalAcc});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevBin  <= '0;
      curBin   <= '0;
      totalAcc <= '0;
      belowAcc <= '0;
      foundQ   <= 1'b0;
      thrQ     <= '0;
    end else if (strobes.clear) begin
      totalAcc <= '0;
      belowAcc <= '0;
      foundQ   <= 1'b0;
      thrQ     <= '0;
    end else if (strobes.dataValid) begin
      prevBin <= curBin;
      curBin  <= rdData;
      if (strobes.countBin) totalAcc <= totalAcc + SUM_W'(rdData);
      if (isValley) begin
        foundQ   <= 1'b1;
        thrQ     <= dataIdx - IDX_W'(1);
        belowAcc <= totalAcc - SUM_W'(curBin);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      thrValid  <= 1'b0;
      thrIdx    <= '0;
      burstSum  <= '0;
      totalSum  <= '0;
      burstFlag <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.finish) begin
        thrValid  <= foundQ;
        thrIdx    <= thrQ;
        burstSum  <= burstNext;
        totalSum  <= totalAcc;
        burstFlag <= flagNext;
      end
    end
  end

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: the flag is never raised without a threshold
  p_flag_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burstFlag |-> thrValid);

  // R6: the burst population is part of the total population
  p_burst_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> burstSum <= totalSum);

  // R10: published results move only together with done
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(burstSum) || !$stable(totalSum) || !$stable(thrIdx) |-> done);

  // R11: the running total never wraps while bins are added
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.countBin && !strobes.clear |=> totalAcc >= $past(totalAcc));
endmodule

// File: rtl/burst_share_detector.sv
module burst_share_detector
  import bsd_pkg::*;
#(
  parameter int NUM_BINS = 128,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = $clog2(NUM_BINS),
  localparam int SUM_W   = CNT_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rdEn,
  output logic [IDX_W-1:0]  rdAddr,
  input  logic [CNT_W-1:0]  rdData,
  output logic              done,
  output logic              thrValid,
  output logic [IDX_W-1:0]  thrIdx,
  output logic [SUM_W-1:0]  burstSum,
  output logic [SUM_W-1:0]  totalSum,
  output logic              burstFlag
);
  ctlStrobes_t      strobes;
  logic [IDX_W-1:0] dataIdx;

  bsd_control #(.NUM_BINS(NUM_BINS), .IDX_W(IDX_W)) control_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .dataIdx (dataIdx),
    .strobes (strobes)
  );

  bsd_datapath #(.CNT_W(CNT_W), .IDX_W(IDX_W), .SUM_W(SUM_W)) datapath_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .dataIdx   (dataIdx),
    .rdData    (rdData),
    .done      (done),
    .thrValid  (thrValid),
    .thrIdx    (thrIdx),
    .burstSum  (burstSum),
    .totalSum  (totalSum),
    .burstFlag (burstFlag)
  );
endmodule

// File: tb/burst_share_detector_tb_top.sv
module burst_share_detector_tb_top;
  localparam int NB = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rdEn;
  logic [6:0]  rdAddr;
  logic [15:0] rdData = '0;
  logic        done;
  logic        thrValid;
  logic [6:0]  thrIdx;
  logic [22:0] burstSum;
  logic [22:0] totalSum;
  logic        burstFlag;

  logic [15:0] mem [NB];

  int checkCount = 0;
  int failCount  = 0;

  int  expThr;
  bit  expFound;
  int  expBurst;
  int  expTotal;
  bit  expFlag;

  always #5 clk = ~clk;

  always_ff @(posedge clk) if (rdEn) rdData <= mem[rdAddr];

  burst_share_detector dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .done(done), .thrValid(thrValid), .thrIdx(thrIdx),
    .burstSum(burstSum), .totalSum(totalSum), .burstFlag(burstFlag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  // reference model written from the requirements
  task automatic computeExpected();
    expFound = 0; expThr = 0; expBurst = 0; expTotal = 0;
    for (int i = 1; i < NB; i++) expTotal += int'(mem[i]);
    for (int i = 1; i <= NB - 2; i++) begin
      if (!expFound && mem[i] < mem[i-1] && mem[i] <= mem[i+1]) begin
        expFound = 1; expThr = i;
      end
    end
    if (expFound) for (int i = expThr; i < NB; i++) expBurst += int'(mem[i]);
    expFlag = expFound && (2 * expBurst > expTotal);
  endtask

  task automatic fillAll(input int v);
    for (int i = 0; i < NB; i++) mem[i] = 16'(v);
  endtask

  task automatic checkResults(input string name);
    check(thrValid == expFound, {name, " R3 thrValid"}, int'(thrValid), int'(expFound));
    if (expFound)
      check(int'(thrIdx) == expThr, {name, " R3 thrIdx"}, int'(thrIdx), expThr);
    else begin
      check(thrIdx == 0, {name, " R4 thrIdx"}, int'(thrIdx), 0);
      check(burstSum == 0, {name, " R4 burstSum"}, int'(burstSum), 0);
    end
    check(int'(totalSum) == expTotal, {name, " R5 totalSum"}, int'(totalSum), expTotal);
    check(int'(burstSum) == expBurst, {name, " R6 burstSum"}, int'(burstSum), expBurst);
    check(burstFlag == expFlag, {name, " R7 burstFlag"}, int'(burstFlag), int'(expFlag));
  endtask

  // start a scan; optionally pulse start again at sample index injectAt
  task automatic runScan(input string name, input int injectAt);
    int  doneAt = -1;
    int  doneHigh = 0;
    bit  seqOk = 1;
    computeExpected();
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    for (int n = 0; n < 140; n++) begin
      if (n > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      if (n == injectAt) start = 1'b1;
      else start = 1'b0;
      if (n < NB) begin
        if (!(rdEn && int'(rdAddr) == n)) seqOk = 0;
      end else if (rdEn) seqOk = 0;
      if (done) begin
        doneHigh++;
        if (doneAt < 0) doneAt = n;
      end
    end
    start = 1'b0;
    check(seqOk, {name, " R2 read sequence"}, int'(seqOk), 1);
    check(doneAt == 130, {name, " R8 done latency"}, doneAt, 130);
    check(doneHigh == 1, {name, " R8 done width"}, doneHigh, 1);
    checkResults(name);
  endtask

  task automatic testReset();
    check(!done && !thrValid && !burstFlag, "R1 flags", int'({done, thrValid, burstFlag}), 0);
    check(thrIdx == 0 && burstSum == 0 && totalSum == 0, "R1 values",
          int'(burstSum) + int'(totalSum) + int'(thrIdx), 0);
  endtask

  task automatic testMidValley();
    fillAll(0);
    mem[0] = 50; mem[1] = 10; mem[2] = 3; mem[3] = 5; mem[4] = 2;
    mem[20] = 40; mem[21] = 35; mem[22] = 12;
    runScan("midValley", -1);
    check(thrIdx == 2, "midValley R3 fixed", int'(thrIdx), 2);
    check(burstFlag == 1'b1, "midValley R7 fixed", int'(burstFlag), 1);
  endtask

  task automatic testHalfShare();
    fillAll(0);
    mem[0] = 9; mem[1] = 4; mem[2] = 1; mem[3] = 1; mem[10] = 2;
    runScan("halfShare", -1);
    check(burstSum == 4 && totalSum == 8 && !burstFlag, "halfShare R7 exact half",
          int'(burstFlag), 0);
    mem[10] = 3;
    runScan("aboveHalf", -1);
    check(burstFlag == 1'b1, "aboveHalf R7", int'(burstFlag), 1);
  endtask

  task automatic testNoValley();
    for (int i = 0; i < NB; i++) mem[i] = 16'(i);
    runScan("ramp", -1);
    fillAll(7);
    runScan("plateau", -1);
    for (int i = 0; i < NB; i++) mem[i] = 16'(i + 1);
    mem[127] = 0;
    runScan("dropAt127", -1);
    check(!thrValid && burstSum == 0 && !burstFlag, "dropAt127 R4", int'(thrValid), 0);
  endtask

  task automatic testBin0Excluded();
    fillAll(1);
    mem[0] = 16'hFFFF; mem[1] = 0;
    runScan("bin1Valley", -1);
    check(thrIdx == 1 && totalSum == 126, "bin1Valley R5 bin0 excluded", int'(totalSum), 126);
  endtask

  task automatic testSaturated();
    fillAll(16'hFFFF);
    runScan("saturated", -1);
    check(int'(totalSum) == 127 * 65535, "saturated R11", int'(totalSum), 127 * 65535);
  endtask

  task automatic testLateValley();
    fillAll(10);
    mem[125] = 9; mem[126] = 1; mem[127] = 1;
    runScan("lateValley", -1);
    check(thrIdx == 126 && burstSum == 2, "lateValley R6", int'(burstSum), 2);
  endtask

  task automatic testBusyStart();
    fillAll(0);
    mem[0] = 20; mem[1] = 6; mem[2] = 2; mem[3] = 4; mem[60] = 30;
    runScan("busyStart R9", 50);
  endtask

  task automatic testHold();
    int b, t, ti, f;
    fillAll(0);
    mem[0] = 8; mem[1] = 5; mem[2] = 1; mem[3] = 1; mem[90] = 9;
    runScan("hold", -1);
    b = int'(burstSum); t = int'(totalSum); ti = int'(thrIdx); f = int'(burstFlag);
    fillAll(3);
    for (int k = 0; k < 20; k++) @(negedge clk);
    check(int'(burstSum) == b && int'(totalSum) == t, "hold R10 sums", int'(totalSum), t);
    check(int'(thrIdx) == ti && int'(burstFlag) == f && !done, "hold R10 thr/flag",
          int'(thrIdx), ti);
  endtask

  initial begin
    fillAll(0);
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testMidValley();
    testHalfShare();
    testNoValley();
    testBin0Excluded();
    testSaturated();
    testLateValley();
    testBusyStart();
    testHold();
    finishRun();
  end
endmodule